// File: doc/BRIEF.md
# Octal Code Register I2C Slave

This block is a receive-only I2C target that keeps eight 6-bit code registers, one per output channel of a trimming converter. It samples the SCL and SDA lines on the system clock, finds start and stop conditions, and compares the received address with a fixed upper part and three strap inputs. A controller writes a channel by sending a frame made of three parts: the address byte, then a command byte, then one or more data bytes. The command byte holds an operation code and a channel index.

The block drives SDA only to pull it low for an acknowledge. The eight codes come out as one flat bus, with channel n at bits `code_o[6n+5:6n]`. Every code resets to zero, which is the lowest output step. There is no read path.

Top module: `octcode_i2c_slave`

## Requirements
- R1: An address byte is acknowledged only when its seven upper bits are 0,1,0,0 followed by `strap_i[2:0]` and its last bit (direction) is 0. A byte with any other value gets no acknowledge, and no register changes until the next start condition.
- R2: An address byte whose direction bit is 1 is never acknowledged, and no register changes in that frame.
- R3: The block pulls SDA low (`sda_pull_o` = 1) only during the ninth clock of an accepted address, command or data byte. At all other times while SCL is high it leaves SDA released.
- R4: In the command byte, bits 7..4 are the operation code and bits 3..0 are the channel index.
- R5: With operation code 0000, each data byte writes the selected channel's code. The code is held on `code_o[6n+5:6n]`.
- R6: With operation code 1111, the first data byte writes the selected channel. Each following data byte writes the next channel, and the index wraps from 7 to 0.
- R7: Data bits 7..6 are discarded. Only bits 5..0 are stored.
- R8: A channel index from 8 to 15 is acknowledged, and its data bytes are acknowledged, but no code changes.
- R9: An operation code other than 0000 or 1111 is acknowledged, together with its data bytes, but no code changes.
- R10: After reset all eight codes are zero.
- R11: A start condition is an SDA fall while SCL is high, and a stop condition is an SDA rise while SCL is high. A start in the middle of a frame drops the frame and begins address matching again. A data byte cut short by a start or a stop writes nothing.
- R12: Bits are shifted in most significant bit first, one on each SCL rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired level) |
| strap_i | input | 3 | Low three bits of the address |
| sda_pull_o | output | 1 | High when the block pulls SDA low |
| code_o | output | 48 | Eight 6-bit channel codes, channel n at bits 6n+5..6n |

## Verification
The bench sets the straps to each of the eight values in turn. For each one it sends a wrong address and then the right one. A design with a bad address compare would acknowledge the wrong address or ignore the right one. Other frames cover the following cases:
- An auto-increment burst that crosses channel 7, which catches a pointer that does not wrap or runs past channel 7.
- A data byte with its two top bits set, which catches a design that stores them.
- Channel indices above 7 and unused operation codes, which would corrupt a channel if the write qualification were wrong.
- A read-direction address, which would be acknowledged by a design that lacks the direction check.
- A repeated start and a stop that each cut off a data byte partway. A design that does not drop the partial frame would leave a wrong value in the channel.

// File: rtl/octcode_pkg.sv
package octcode_pkg;
   localparam int BYTE_BITS = 8;
   localparam int IDX_W     = 4;
   localparam logic [3:0] OP_SINGLE = 4'h0;
   localparam logic [3:0] OP_AUTO   = 4'hF;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_CMD,
      PH_DATA,
      PH_SKIP
   } phase_e;
endpackage

// File: rtl/octcode_line_sync.sv
module octcode_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("octcode_line_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= line_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], line_i};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign lvl_o  = chain_q[STAGES-1];
   assign rise_o = chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/octcode_frame_rx.sv
module octcode_frame_rx
   import octcode_pkg::*;
#(
   parameter int          NUM_CH  = 8,
   parameter int          CODE_W  = 6,
   parameter logic [3:0]  ADDR_HI = 4'b0100,
   localparam int         CH_W    = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_lvl,
   input  logic              sda_rise,
   input  logic              sda_fall,
   input  logic [2:0]        strap_i,
   output logic              sda_pull_o,
   output logic              wr_en_o,
   output logic [CH_W-1:0]   wr_idx_o,
   output logic [CODE_W-1:0] wr_data_o
);
   localparam logic [CH_W-1:0] IDX_ONE = CH_W'(1);

   phase_e               phase_q;
   logic [3:0]           bitcnt_q;
   logic [BYTE_BITS-1:0] shift_q;
   logic [3:0]           op_q;
   logic [IDX_W-1:0]     idx_q;
   logic                 pull_q;
   logic                 wr_q;
   logic [CH_W-1:0]      wr_idx_q;
   logic [CODE_W-1:0]    wr_data_q;

   logic start_evt, stop_evt, busy, byte_done, ack_done;
   logic addr_hit, idx_ok, op_writes;

   assign start_evt = sda_fall & scl_lvl;
   assign stop_evt  = sda_rise & scl_lvl;
   assign busy      = (phase_q != PH_IDLE) && (phase_q != PH_SKIP);
   assign byte_done = busy & scl_fall & (bitcnt_q == 4'd8);
   assign ack_done  = busy & scl_fall & (bitcnt_q == 4'd9);
   assign addr_hit  = (shift_q[7:1] == {ADDR_HI[3:0], strap_i}) & ~shift_q[0];
   assign idx_ok    = ({1'b0, idx_q} < 5'(NUM_CH));
   assign op_writes = (op_q == OP_SINGLE) || (op_q == OP_AUTO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         bitcnt_q  <= '0;
         shift_q   <= '0;
         op_q      <= '0;
         idx_q     <= '0;
         pull_q    <= 1'b0;
         wr_q      <= 1'b0;
         wr_idx_q  <= '0;
         wr_data_q <= '0;
      end else begin
         wr_q <= 1'b0;
         if (start_evt) begin
            phase_q  <= PH_ADDR;
            bitcnt_q <= '0;
            pull_q   <= 1'b0;
         end else if (stop_evt) begin
            phase_q  <= PH_IDLE;
            bitcnt_q <= '0;
            pull_q   <= 1'b0;
         end else if (busy) begin
            if (scl_rise && bitcnt_q < 4'd8) begin
               shift_q  <= {shift_q[BYTE_BITS-2:0], sda_lvl};
               bitcnt_q <= bitcnt_q + 4'd1;
            end else if (byte_done) begin
               bitcnt_q <= 4'd9;
               unique case (phase_q)
                  PH_ADDR: begin
                     if (addr_hit) pull_q  <= 1'b1;
                     else          phase_q <= PH_SKIP;
                  end
                  PH_CMD: begin
                     pull_q <= 1'b1;
                     op_q   <= shift_q[7:4];
                     idx_q  <= shift_q[IDX_W-1:0];
                  end
                  PH_DATA: begin
                     pull_q <= 1'b1;
                     if (idx_ok && op_writes) begin
                        wr_q      <= 1'b1;
                        wr_idx_q  <= idx_q[CH_W-1:0];
                        wr_data_q <= shift_q[CODE_W-1:0];
                        if (op_q == OP_AUTO)
                           idx_q[CH_W-1:0] <= idx_q[CH_W-1:0] + IDX_ONE;
                     end
                  end
                  default: ;
               endcase
            end else if (ack_done) begin
               pull_q   <= 1'b0;
               bitcnt_q <= '0;
               if (phase_q == PH_ADDR)     phase_q <= PH_CMD;
               else if (phase_q == PH_CMD) phase_q <= PH_DATA;
            end
         end
      end
   end

   assign sda_pull_o = pull_q;
   assign wr_en_o    = wr_q;
   assign wr_idx_o   = wr_idx_q;
   assign wr_data_o  = wr_data_q;

   AST_ADDR_RD_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && phase_q == PH_ADDR && shift_q[0] && !start_evt && !stop_evt) |=> !pull_q); // R2
   AST_NO_PULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE || phase_q == PH_SKIP) |-> !pull_q); // R3
   AST_WR_IN_DATA_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |-> (phase_q == PH_DATA && pull_q)); // R5
   AST_WR_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |=> !wr_q); // R5
endmodule

// File: rtl/octcode_reg_bank.sv
module octcode_reg_bank #(
   parameter int  NUM_CH = 8,
   parameter int  CODE_W = 6,
   localparam int CH_W   = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en_i,
   input  logic [CH_W-1:0]          wr_idx_i,
   input  logic [CODE_W-1:0]        wr_data_i,
   output logic [NUM_CH*CODE_W-1:0] code_o
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
         logic [CODE_W-1:0] code_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  code_q <= '0;
            else if (wr_en_i && wr_idx_i == CH_W'(gi))   code_q <= wr_data_i;
         end
         assign code_o[gi*CODE_W +: CODE_W] = code_q;
      end
   endgenerate

   AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(code_o)); // R9
endmodule

// File: rtl/octcode_i2c_slave.sv
module octcode_i2c_slave #(
   parameter int          NUM_CH      = 8,
   parameter int          CODE_W      = 6,
   parameter int          SYNC_STAGES = 2,
   parameter logic [3:0]  ADDR_HI     = 4'b0100,
   localparam int         CH_W        = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scl_i,
   input  logic                     sda_i,
   input  logic [2:0]               strap_i,
   output logic                     sda_pull_o,
   output logic [NUM_CH*CODE_W-1:0] code_o
);
   generate
      if (NUM_CH < 2 || NUM_CH > 16 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
         $error("octcode_i2c_slave: NUM_CH must be a power of two from 2 to 16");
      end
      if (CODE_W < 1 || CODE_W > 8) begin : g_bad_code
         $error("octcode_i2c_slave: CODE_W must lie in 1..8");
      end
   endgenerate

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   logic              wr_en;
   logic [CH_W-1:0]   wr_idx;
   logic [CODE_W-1:0] wr_data;

   octcode_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

   octcode_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

   octcode_frame_rx #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_HI(ADDR_HI)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
      .strap_i(strap_i), .sda_pull_o(sda_pull_o),
      .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data));

   octcode_reg_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
      .code_o(code_o));
endmodule

// File: tb/octcode_i2c_slave_tb.sv
module octcode_i2c_slave_tb;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_drv = 1'b1;
   logic [2:0]  strap = 3'd0;
   logic        sda_pull;
   logic [47:0] code;
   logic        line;

   int n_checks = 0;
   int n_fail = 0;
   int stray = 0;
   bit done = 1'b0;
   logic [5:0] exp_code [0:7];
   logic [7:0] dbuf [0:7];
   bit ack_a, ack_c;
   bit ack_d [0:7];

   assign line = sda_drv & ~sda_pull;

   always #(CLK_PERIOD/2) clk = ~clk;

   octcode_i2c_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line),
      .strap_i(strap), .sda_pull_o(sda_pull), .code_o(code));

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      for (int c = 0; c < 8; c++) chk(req, int'(code[c*6 +: 6]), int'(exp_code[c]));
   endtask

   task automatic qwait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_drv = 1'b1; qwait();
      scl = 1'b1;     qwait();
      sda_drv = 1'b0; qwait();
      scl = 1'b0;     qwait();
   endtask

   task automatic bus_stop();
      sda_drv = 1'b0; qwait();
      scl = 1'b1;     qwait();
      sda_drv = 1'b1; qwait();
   endtask

   task automatic send_bit(input bit b);
      sda_drv = b; qwait();
      scl = 1'b1;  qwait();
      if (sda_pull) stray++;
      qwait();
      scl = 1'b0;  qwait();
   endtask

   task automatic send_byte(input logic [7:0] v, output bit ack);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      sda_drv = 1'b1; qwait();
      scl = 1'b1;     qwait();
      ack = ~line;
      qwait();
      scl = 1'b0;     qwait();
   endtask

   // full frame: address, command, n data bytes from dbuf, then stop
   task automatic frame(input logic [2:0] a, input bit rw, input logic [7:0] cmd, input int n);
      bus_start();
      send_byte({4'b0100, a, rw}, ack_a);
      if (ack_a) begin
         send_byte(cmd, ack_c);
         for (int k = 0; k < n; k++) send_byte(dbuf[k], ack_d[k]);
      end
      bus_stop();
   endtask

   // expected-value model from the requirements
   task automatic model(input logic [7:0] cmd, input int n);
      int op, ch;
      op = int'(cmd[7:4]);
      ch = int'(cmd[3:0]);
      if (ch < 8 && (op == 0 || op == 15)) begin
         for (int k = 0; k < n; k++) begin
            exp_code[ch] = dbuf[k][5:0];
            if (op == 15) ch = (ch + 1) % 8;
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      bit a;
      for (int c = 0; c < 8; c++) exp_code[c] = 6'd0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk_all("R10 reset codes");

      // R1: strap sweep, wrong then right address
      for (int s = 0; s < 8; s++) begin
         strap = 3'(s);
         dbuf[0] = 8'(((s * 9) + 5) % 64);
         frame(3'((s + 3) % 8), 1'b0, {4'h0, 4'(s)}, 1);
         chk("R1 mismatch nack", int'(ack_a), 0);
         chk_all("R1 mismatch no write");
         frame(3'(s), 1'b0, {4'h0, 4'(s)}, 1);
         chk("R1 match ack", int'(ack_a), 1);
         chk("R3 cmd ack", int'(ack_c), 1);
         chk("R3 data ack", int'(ack_d[0]), 1);
         model({4'h0, 4'(s)}, 1);
         chk_all("R1 R5 write");
      end
      strap = 3'd5;

      // R12: bit order
      dbuf[0] = 8'h01; frame(3'd5, 1'b0, 8'h00, 1); model(8'h00, 1);
      dbuf[0] = 8'h20; frame(3'd5, 1'b0, 8'h01, 1); model(8'h01, 1);
      chk("R12 lsb lands low", int'(code[5:0]), 1);
      chk("R12 msb lands high", int'(code[11:6]), 32);

      // R7: top data bits dropped
      dbuf[0] = 8'hD5; frame(3'd5, 1'b0, 8'h04, 1); model(8'h04, 1);
      chk("R7 top bits dropped", int'(code[4*6 +: 6]), 21);

      // R5: several bytes to one channel
      dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h3C;
      frame(3'd5, 1'b0, 8'h02, 3); model(8'h02, 3);
      chk("R5 last byte kept", int'(code[2*6 +: 6]), 60);
      chk_all("R5 single channel");

      // R6: auto increment across the wrap
      for (int k = 0; k < 5; k++) dbuf[k] = 8'(40 + k);
      frame(3'd5, 1'b0, 8'hF6, 5); model(8'hF6, 5);
      chk("R6 wrap to ch0", int'(code[5:0]), 42);
      chk_all("R6 auto increment");

      // R8: channel index out of range
      dbuf[0] = 8'h3F; dbuf[1] = 8'h3F;
      frame(3'd5, 1'b0, 8'h09, 1);
      chk("R8 data acked", int'(ack_d[0]), 1);
      frame(3'd5, 1'b0, 8'hFC, 2);
      chk("R8 auto data acked", int'(ack_d[1]), 1);
      chk_all("R8 no write");

      // R9 / R4: other operation codes
      frame(3'd5, 1'b0, 8'h53, 1);
      chk("R9 acked", int'(ack_d[0]), 1);
      chk_all("R9 no write");
      frame(3'd5, 1'b0, 8'h17, 1);
      chk_all("R4 op nibble decoded");
      dbuf[0] = 8'h0B; frame(3'd5, 1'b0, 8'h07, 1); model(8'h07, 1);
      chk("R4 index nibble", int'(code[7*6 +: 6]), 11);

      // R2: read direction
      frame(3'd5, 1'b1, 8'h00, 0);
      chk("R2 read nack", int'(ack_a), 0);
      chk_all("R2 no write");

      // R11: repeated start inside a data byte
      bus_start();
      send_byte(8'h4A, a);
      send_byte(8'h04, a);
      for (int i = 0; i < 4; i++) send_bit(1'b1);
      bus_start();
      send_byte(8'h4A, a);
      chk("R11 restart ack", int'(a), 1);
      send_byte(8'h03, a);
      send_byte(8'h2D, a);
      bus_stop();
      dbuf[0] = 8'h2D; model(8'h03, 1);
      chk("R11 restart write", int'(code[3*6 +: 6]), 45);
      chk_all("R11 aborted byte");
      // stop inside a data byte
      bus_start();
      send_byte(8'h4A, a);
      send_byte(8'h05, a);
      for (int i = 0; i < 5; i++) send_bit(1'b0);
      bus_stop();
      chk_all("R11 stop abort");

      chk("R3 no stray pull", stray, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule